// File: doc/BRIEF.md
# Newton-Refined Reciprocal and Inverse Square Root Unit

This block is a fixed-point arithmetic unit. It computes either 1/x or 1/sqrt(x) for an unsigned operand that is already normalized into the range [1, 2). A small read-only seed table gives a first guess. The table is addressed by the mode bit and the six fraction bits just below the integer bit. Two Newton-Raphson passes then sharpen the guess.

The reciprocal pass is y' = y(2 - xy), which takes two products. The inverse-root pass is y' = y(3 - xy^2)/2, which takes three products. All products go through a single shared multiplier, and a small state machine steps through them one per clock. Intermediate values are held with 24 fraction bits. The final value is truncated to the output format.

A client drives `start` for one cycle together with `operand` and `mode`. It then waits for the one-cycle `done` pulse and reads `result`. Requests made while the unit is busy are dropped. Both operand and result are unsigned Q1.15.

Top module: `nr_recip_unit`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `result` are all zero.
- R2: With `mode` = 0 (reciprocal), the accepted operand is Q1.15 with bit 15 set. The result is Q1.15 and lies within 2 LSB of 2^30 / operand.
- R3: With `mode` = 1 (inverse square root), the result is Q1.15 and lies within 2 LSB of 2^15 / sqrt(operand / 2^15).
- R4: Every result delivered with `done` lies in the range 0x4000 to 0x8000 inclusive.
- R5: In reciprocal mode, `done` is high in the cycle after the 5th rising edge that follows the edge which accepted `start`.
- R6: In inverse-root mode, `done` is high in the cycle after the 7th rising edge that follows the accepting edge.
- R7: `busy` goes high on the edge that accepts `start` and stays high until the edge that raises `done`. `busy` is low whenever `done` is high.
- R8: `start` is ignored while `busy` is high. The operand, the mode, the latency and the number of `done` pulses all stay as set by the accepted request.
- R9: `done` lasts exactly one cycle. `result` changes only on the edge that raises `done` and then holds until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; accepted only while idle |
| mode | input | 1 | 0 = reciprocal, 1 = inverse square root |
| operand | input | 16 | Unsigned Q1.15 input in [1, 2) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 16 | Unsigned Q1.15 result |

## Verification
Each fault has a distinct signature at the ports.

- A corrupted seed entry only shows for operands in its 1/64 segment. The bench therefore hits segment edges directly and also sweeps many random operands. Such a fault appears as an error far above 2 LSB on the very first `done`.
- A wrong step count or a wrong operand choice in the sequencer moves `done` away from cycle 5 or 7, or leaves a large residual error.
- A latch that wrongly reloads while busy shows as a result that matches the second request instead of the first.

// File: rtl/nr_pkg.sv
package nr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN
  } nr_state_e;

  localparam logic MODE_RECIP = 1'b0;
  localparam logic MODE_RSQRT = 1'b1;

endpackage

// File: rtl/nr_seed_rom.sv
module nr_seed_rom #(
  parameter int IDXB = 6,
  parameter int SW   = 16
) (
  input  logic            clk,
  input  logic [IDXB:0]   addr,
  output logic [SW-1:0]   seed
);

  localparam int ENTRIES = 1 << IDXB;
  localparam int DEPTH   = 2 * ENTRIES;

  logic [SW-1:0] mem [DEPTH];

  function automatic longint unsigned isqrt(input longint unsigned v);
    longint unsigned rem;
    longint unsigned root;
    longint unsigned bitv;
    rem  = v;
    root = 0;
    bitv = 64'h1 << 62;
    for (int k = 0; k < 32; k++) begin
      if (rem >= root + bitv) begin
        rem  = rem - (root + bitv);
        root = (root >> 1) + bitv;
      end else begin
        root = root >> 1;
      end
      bitv = bitv >> 2;
    end
    return root;
  endfunction

  // Segment midpoint m = (2E + 2i + 1) / 2E ; seed = 1/m or 1/sqrt(m), Q0.SW
  function automatic logic [SW-1:0] seed_val(input int k);
    longint unsigned den;
    longint unsigned num;
    longint unsigned val;
    den = longint'(2 * ENTRIES + 2 * (k % ENTRIES) + 1);
    if (k >= ENTRIES) begin
      num = (longint'(1) << (2 * SW)) * longint'(2 * ENTRIES);
      val = isqrt(num / den);
    end else begin
      num = (longint'(1) << SW) * longint'(2 * ENTRIES);
      val = num / den;
    end
    return SW'(val);
  endfunction

  initial begin
    for (int k = 0; k < DEPTH; k++) mem[k] = seed_val(k);
  end

  always_ff @(posedge clk) seed <= mem[addr];

endmodule

// File: rtl/nr_mul.sv
module nr_mul #(
  parameter int IW = 26,
  parameter int FB = 24
) (
  input  logic [IW-1:0] a,
  input  logic [IW-1:0] b,
  output logic [IW-1:0] p
);

  localparam int PW = 2 * IW;

  logic [PW-1:0] prod;

  assign prod = {{IW{1'b0}}, a} * {{IW{1'b0}}, b};
  assign p    = IW'(prod >> FB);

endmodule

// File: rtl/nr_recip_unit.sv
module nr_recip_unit
  import nr_pkg::*;
#(
  parameter int XW   = 16,
  parameter int IDXB = 6,
  parameter int SW   = 16,
  parameter int FB   = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode,
  input  logic [XW-1:0] operand,
  output logic          busy,
  output logic          done,
  output logic [XW-1:0] result
);

  localparam int IW    = FB + 2;
  localparam int OSH   = FB - XW + 1;
  localparam logic [IW-1:0] TWO   = IW'(2) << FB;
  localparam logic [IW-1:0] THREE = IW'(3) << FB;

  nr_state_e     state;
  logic [XW-1:0] op_q;
  logic          mode_q;
  logic [IW-1:0] y_q;
  logic [IW-1:0] t_q;
  logic [1:0]    step;
  logic          iter;

  logic [IDXB:0] rom_addr;
  logic [SW-1:0] rom_q;
  logic [IW-1:0] x_ext;
  logic [IW-1:0] seed_ext;
  logic [IW-1:0] mul_a;
  logic [IW-1:0] mul_b;
  logic [IW-1:0] mul_p;
  logic [IW-1:0] y_next;
  logic          last_step;
  logic          accept;

  assign rom_addr = {mode, operand[XW-2 -: IDXB]};
  assign accept   = start && (state == ST_IDLE);
  assign x_ext    = {1'b0, op_q, {OSH{1'b0}}};
  assign seed_ext = {2'b00, rom_q, {(FB - SW){1'b0}}};

  nr_seed_rom #(.IDXB(IDXB), .SW(SW)) u_rom (
    .clk  (clk),
    .addr (rom_addr),
    .seed (rom_q)
  );

  nr_mul #(.IW(IW), .FB(FB)) u_mul (
    .a (mul_a),
    .b (mul_b),
    .p (mul_p)
  );

  always_comb begin
    mul_a     = y_q;
    mul_b     = y_q;
    last_step = 1'b0;
    if (mode_q == MODE_RECIP) begin
      if (step == 2'd0) begin
        mul_a = x_ext;
        mul_b = y_q;
      end else begin
        mul_a     = y_q;
        mul_b     = TWO - t_q;
        last_step = 1'b1;
      end
    end else begin
      case (step)
        2'd0: begin
          mul_a = y_q;
          mul_b = y_q;
        end
        2'd1: begin
          mul_a = x_ext;
          mul_b = t_q;
        end
        default: begin
          mul_a     = y_q;
          mul_b     = THREE - t_q;
          last_step = 1'b1;
        end
      endcase
    end
    y_next = (mode_q == MODE_RSQRT) ? (mul_p >> 1) : mul_p;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_q   <= '0;
      mode_q <= MODE_RECIP;
      y_q    <= '0;
      t_q    <= '0;
      step   <= '0;
      iter   <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q   <= operand;
            mode_q <= mode;
            busy   <= 1'b1;
            state  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          y_q   <= seed_ext;
          step  <= '0;
          iter  <= 1'b0;
          state <= ST_RUN;
        end
        default: begin
          if (!last_step) begin
            t_q  <= mul_p;
            step <= step + 2'd1;
          end else begin
            y_q  <= y_next;
            step <= '0;
            if (iter) begin
              result <= y_next[OSH +: XW];
              done   <= 1'b1;
              busy   <= 1'b0;
              state  <= ST_IDLE;
            end else begin
              iter <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(op_q) && $stable(mode_q)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  // R4
  result_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ((result <= XW'(1 << (XW - 1))) && (result[XW-1 -: 2] != 2'b00)));

endmodule

// File: tb/nr_recip_unit_test.sv
`timescale 1ns/1ps
module nr_recip_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] operand = 16'h8000;
  logic        busy;
  logic        done;
  logic [15:0] result;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  nr_recip_unit uut (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mode    (mode),
    .operand (operand),
    .busy    (busy),
    .done    (done),
    .result  (result)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check_int(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real exact_val(input logic [15:0] x, input logic m);
    real xr;
    xr = real'(x) / 32768.0;
    if (m) return 32768.0 / $sqrt(xr);
    return 32768.0 / xr;
  endfunction

  // issue one request and measure; returns result and latency
  task automatic run_op(input logic [15:0] x, input logic m,
                        output logic [15:0] res, output int lat);
    @(negedge clk);
    start = 1'b1;
    operand = x;
    mode = m;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check_int(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      lat = lat + 1;
      @(negedge clk);
      if (done) break;
    end
    res = result;
    check_int(busy == 1'b0, "R7 busy low with done", int'(busy), 0);
  endtask

  task automatic check_acc(input logic [15:0] x, input logic m, input logic [15:0] res);
    real ex;
    real d;
    ex = exact_val(x, m);
    d = real'(res) - ex;
    if (d < 0.0) d = -d;
    checks = checks + 1;
    if (d > 2.0) begin
      failures = failures + 1;
      $display("FAIL %s x=%h: actual=%0d expected=%0.3f", m ? "R3" : "R2", x, res, ex);
    end
    check_int((res >= 16'h4000) && (res <= 16'h8000), "R4 range", int'(res), 16'h8000);
  endtask

  task automatic full_op(input logic [15:0] x, input logic m);
    logic [15:0] res;
    int lat;
    run_op(x, m, res, lat);
    check_int(lat == (m ? 7 : 5), m ? "R6 latency" : "R5 latency", lat, m ? 7 : 5);
    check_acc(x, m, res);
  endtask

  initial begin
    logic [15:0] res;
    logic [15:0] held;
    int lat;
    int r;
    logic [15:0] corners [8];
    corners[0] = 16'h8000; corners[1] = 16'hFFFF; corners[2] = 16'h81FF;
    corners[3] = 16'h8200; corners[4] = 16'hC000; corners[5] = 16'hBFFF;
    corners[6] = 16'hB505; corners[7] = 16'hFE00;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_int(busy == 0 && done == 0 && result == 0, "R1 during reset", int'(result), 0);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_int(busy == 0 && done == 0 && result == 0, "R1 after reset", int'(result), 0);

    // R2 R3 R5 R6: directed corners, both modes
    for (int i = 0; i < 8; i++) begin
      full_op(corners[i], 1'b0);
      full_op(corners[i], 1'b1);
    end

    // R8: start held with other operands while busy
    @(negedge clk);
    start = 1'b1; operand = 16'hA000; mode = 1'b1;
    @(posedge clk);
    @(negedge clk);
    operand = 16'hF000; mode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    operand = 16'h8800;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    for (int k = 0; k < 20; k++) begin
      if (done) break;
      @(posedge clk);
      lat = lat + 1;
      @(negedge clk);
    end
    lat = lat - 1;
    check_int(lat == 7, "R8 latency of first request", lat, 7);
    check_acc(16'hA000, 1'b1, result);
    held = result;
    // R9: done is one cycle, no second pulse, result holds
    r = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done || busy) r = r + 1;
      if (result != held) r = r + 100;
    end
    check_int(r == 0, "R8 R9 no extra pulse and result held", r, 0);

    // R2 R3: random operands, fixed seed
    r = $urandom(32'h5EED);
    for (int i = 0; i < 300; i++) begin
      logic [15:0] x;
      logic m;
      r = $urandom();
      x = 16'h8000 | 16'(r & 32'h7FFF);
      m = r[20];
      run_op(x, m, res, lat);
      check_int(lat == (m ? 7 : 5), m ? "R6 latency" : "R5 latency", lat, m ? 7 : 5);
      check_acc(x, m, res);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule